// File: doc/BRIEF.md
# Keyword-Based Configuration Autoloader

This block recovers configuration values from a nonvolatile store that holds them as keyword/data pairs instead of a fixed layout. After a start pulse it issues dword reads through a simple request/response read port, beginning at a base offset chosen by the source select (EEPROM region or flash region) and stepping by four bytes per read. A keyword dword names a target register in its upper half. The dword after it carries that register's value. The scan stops at the first dword that is not a keyword where a keyword is expected, or when a read fails or times out.

Only the two station-address registers are of interest. Their values are captured and assembled into a 48-bit MAC address. The block then reports completion, any error, and whether the assembled address is usable as a unicast station address. The physical EEPROM or flash protocol sits behind the read port and is not part of this block.

Top module: `kw_cfg_loader`

## Requirements
- R1: An accepted start launches reads at byte offset 0x100 when `src_sel` is 0, or 0x1F000 when it is 1. Each completed read advances the offset by 4.
- R2: Every offset presented on `rd_addr` while `rd_req` is high has bits [1:0] equal to zero. A base parameter that is not a multiple of 4 is rejected at elaboration.
- R3: A completed read whose bits [7:0] equal 0x5A, arriving where a keyword is expected, is a keyword. Its bits [31:16] give the target register number. Bits [15:8] are ignored.
- R4: The dword after a keyword is always taken as data, even if its low byte is 0x5A. After that dword, the next dword is expected to be a keyword again.
- R5: A non-keyword dword where a keyword is expected ends the scan. `done` becomes 1, `err` stays 0, and `rd_req` goes low.
- R6: A read that returns `rd_err` ends the scan with `done` and `err` both 1. Values captured before the failure are kept.
- R7: A read that gets neither `rd_ack` nor `rd_err` within TIMEOUT_CYC cycles of request ends the scan with `done` and `err` both 1. A response in the TIMEOUT_CYC-th cycle is still accepted.
- R8: Data for register STA_REG goes to the low word (32 bits). Data for STA_REG+4 goes to the high word, and only its bits [15:0] are kept. Data for any other register changes nothing.
- R9: `mac_addr` is {high[15:0], low[31:0]}. MAC byte 0 is bits [47:40] (from high[15:8]), byte 1 is high[7:0], and bytes 2 to 5 are low[31:24] down to low[7:0].
- R10: `mac_valid` is 1 only while `done` is 1, `mac_addr` is not all zero, and `mac_addr[40]` (the multicast bit of byte 0) is 0.
- R11: A start accepted while idle or done clears both captured words before the scan begins. A start while a scan is running is ignored.
- R12: After reset, `rd_req`, `busy`, `done`, `err` and `mac_valid` are 0 and `mac_addr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle pulse that launches a scan |
| src_sel | input | 1 | Region select: 0 = EEPROM base, 1 = flash base |
| rd_req | output | 1 | Read request, held until a response or a timeout |
| rd_addr | output | ADDR_W | Byte offset of the requested dword |
| rd_ack | input | 1 | Read completed; `rd_data` is valid in this cycle |
| rd_err | input | 1 | Read failed; takes priority over `rd_ack` |
| rd_data | input | 32 | Returned dword |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Scan finished; held until the next accepted start |
| err | output | 1 | The last scan ended on a read failure or timeout |
| mac_addr | output | 48 | Assembled station address |
| mac_valid | output | 1 | Assembled address is a usable unicast address |

## Verification
A wrong expect-keyword/expect-data phase shows at the ports on the next read. A data word gets treated as a keyword, so the scan ends one or more reads early, or runs past the terminator. Either way the read count and `mac_addr` change when `done` rises. A wrong offset register is visible on `rd_addr` in the same cycle as the bad read. A wrong register match or byte mapping shows only as a wrong `mac_addr` or `mac_valid` once the scan ends. The sweep therefore varies the order of the two station words, the latency and the region, and compares every finished scan against an arithmetic model.

// File: rtl/kwl_pkg.sv
package kwl_pkg;
   localparam logic [7:0] KEY_MARK = 8'h5A;
   localparam int         DWORD_W  = 32;
   localparam int         MAC_W    = 48;

   typedef enum logic [1:0] {
      SC_IDLE = 2'd0,
      SC_READ = 2'd1,
      SC_DONE = 2'd2
   } scan_st_t;

   function automatic logic is_key(input logic [7:0] lo_byte);
      return lo_byte == KEY_MARK;
   endfunction
endpackage

// File: rtl/kwl_seq.sv
module kwl_seq
   import kwl_pkg::*;
#(
   parameter int                ADDR_W      = 20,
   parameter logic [ADDR_W-1:0] EE_BASE     = 'h100,
   parameter logic [ADDR_W-1:0] FL_BASE     = 'h1F000,
   parameter int                TIMEOUT_CYC = 64
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              src_sel,
   input  logic              rd_ack,
   input  logic              rd_err,
   input  logic              key_seen,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic              clr,
   output logic              kw_hit,
   output logic              dat_hit
);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

   scan_st_t          st_q;
   logic [ADDR_W-1:0] addr_q;
   logic              want_dat_q;
   logic              err_q;
   logic              tout;
   logic              resp;

   assign resp    = rd_ack | rd_err;
   assign rd_req  = (st_q == SC_READ);
   assign rd_addr = addr_q;
   assign busy    = (st_q == SC_READ);
   assign done    = (st_q == SC_DONE);
   assign err     = err_q;
   assign clr     = start & (st_q != SC_READ);
   assign kw_hit  = rd_req & rd_ack & ~rd_err & ~want_dat_q & key_seen;
   assign dat_hit = rd_req & rd_ack & ~rd_err & want_dat_q;

   generate
      if (TIMEOUT_CYC > 0) begin : g_timer
         localparam int TW = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
         localparam logic [TW-1:0] T_LAST = TW'(TIMEOUT_CYC - 1);
         logic [TW-1:0] wait_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 wait_q <= '0;
            else if (!rd_req || resp)   wait_q <= '0;
            else if (wait_q != T_LAST)  wait_q <= wait_q + 1'b1;
         end
         assign tout = rd_req & ~resp & (wait_q == T_LAST);
      end else begin : g_no_timer
         assign tout = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= SC_IDLE;
         addr_q     <= '0;
         want_dat_q <= 1'b0;
         err_q      <= 1'b0;
      end else begin
         unique case (st_q)
            SC_READ: begin
               if (rd_err) begin
                  st_q  <= SC_DONE;
                  err_q <= 1'b1;
               end else if (rd_ack) begin
                  if (want_dat_q) begin
                     want_dat_q <= 1'b0;
                     addr_q     <= addr_q + STEP;
                  end else if (key_seen) begin
                     want_dat_q <= 1'b1;
                     addr_q     <= addr_q + STEP;
                  end else begin
                     st_q <= SC_DONE;
                  end
               end else if (tout) begin
                  st_q  <= SC_DONE;
                  err_q <= 1'b1;
               end
            end
            default: begin
               if (start) begin
                  st_q       <= SC_READ;
                  addr_q     <= src_sel ? FL_BASE : EE_BASE;
                  want_dat_q <= 1'b0;
                  err_q      <= 1'b0;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/kwl_match.sv
module kwl_match
   import kwl_pkg::*;
#(
   parameter int             REG_W   = 16,
   parameter logic [REG_W-1:0] STA_REG = 16'h0140,
   parameter int             HI_W    = 16
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               kw_hit,
   input  logic               dat_hit,
   input  logic [DWORD_W-1:0] rd_data,
   output logic [DWORD_W-1:0] lo_word,
   output logic [HI_W-1:0]    hi_word
);
   localparam logic [REG_W-1:0] STA_HI = STA_REG + REG_W'(4);

   logic [REG_W-1:0] key_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_q   <= '0;
         lo_word <= '0;
         hi_word <= '0;
      end else if (clr) begin
         key_q   <= '0;
         lo_word <= '0;
         hi_word <= '0;
      end else if (kw_hit) begin
         key_q <= rd_data[DWORD_W-1 -: REG_W];
      end else if (dat_hit) begin
         if (key_q == STA_REG)     lo_word <= rd_data;
         else if (key_q == STA_HI) hi_word <= rd_data[HI_W-1:0];
      end
   end
endmodule

// File: rtl/kwl_addr_chk.sv
module kwl_addr_chk
   import kwl_pkg::*;
#(
   parameter int HI_W = 16
)(
   input  logic [DWORD_W-1:0] lo_word,
   input  logic [HI_W-1:0]    hi_word,
   output logic [MAC_W-1:0]   mac,
   output logic               usable
);
   localparam int MCAST_BIT = MAC_W - 8;

   assign mac    = {hi_word, lo_word};
   assign usable = (|mac) & ~mac[MCAST_BIT];
endmodule

// File: rtl/kw_cfg_loader.sv
module kw_cfg_loader
   import kwl_pkg::*;
#(
   parameter int                ADDR_W      = 20,
   parameter logic [ADDR_W-1:0] EE_BASE     = 'h100,
   parameter logic [ADDR_W-1:0] FL_BASE     = 'h1F000,
   parameter int                TIMEOUT_CYC = 64,
   parameter int                REG_W       = 16,
   parameter logic [REG_W-1:0]  STA_REG     = 16'h0140
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              src_sel,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_ack,
   input  logic              rd_err,
   input  logic [31:0]       rd_data,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic [47:0]       mac_addr,
   output logic              mac_valid
);
   localparam int HI_W = MAC_W - DWORD_W;

   generate
      if (EE_BASE[1:0] != 2'b00) begin : g_bad_ee
         $error("EE_BASE must be dword aligned");
      end
      if (FL_BASE[1:0] != 2'b00) begin : g_bad_fl
         $error("FL_BASE must be dword aligned");
      end
      if (REG_W > DWORD_W - 8) begin : g_bad_reg
         $error("REG_W overlaps the keyword byte");
      end
      if (ADDR_W < 3) begin : g_bad_aw
         $error("ADDR_W too small");
      end
      if (TIMEOUT_CYC < 0) begin : g_bad_to
         $error("TIMEOUT_CYC must not be negative");
      end
   endgenerate

   logic               clr, kw_hit, dat_hit, usable;
   logic [DWORD_W-1:0] lo_word;
   logic [HI_W-1:0]    hi_word;

   kwl_seq #(
      .ADDR_W(ADDR_W), .EE_BASE(EE_BASE), .FL_BASE(FL_BASE),
      .TIMEOUT_CYC(TIMEOUT_CYC)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .src_sel(src_sel),
      .rd_ack(rd_ack), .rd_err(rd_err), .key_seen(is_key(rd_data[7:0])),
      .rd_req(rd_req), .rd_addr(rd_addr), .busy(busy), .done(done),
      .err(err), .clr(clr), .kw_hit(kw_hit), .dat_hit(dat_hit)
   );

   kwl_match #(.REG_W(REG_W), .STA_REG(STA_REG), .HI_W(HI_W)) u_match (
      .clk(clk), .rst_n(rst_n), .clr(clr), .kw_hit(kw_hit),
      .dat_hit(dat_hit), .rd_data(rd_data),
      .lo_word(lo_word), .hi_word(hi_word)
   );

   kwl_addr_chk #(.HI_W(HI_W)) u_chk (
      .lo_word(lo_word), .hi_word(hi_word), .mac(mac_addr), .usable(usable)
   );

   assign mac_valid = done & usable;
endmodule

// File: rtl/kwl_checker.sv
module kwl_checker #(
   parameter int ADDR_W      = 20,
   parameter int TIMEOUT_CYC = 64
)(
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              rd_req,
   input logic [ADDR_W-1:0] rd_addr,
   input logic              rd_ack,
   input logic              rd_err,
   input logic              busy,
   input logic              done,
   input logic              err,
   input logic [47:0]       mac_addr,
   input logic              mac_valid
);
   int unsigned wait_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                wait_cnt <= 0;
      else if (rd_req && !rd_ack && !rd_err)     wait_cnt <= wait_cnt + 1;
      else                                       wait_cnt <= 0;
   end

   assert_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> rd_addr[1:0] == 2'b00);

   assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && rd_ack && !rd_err) |=> (!rd_req || rd_addr == $past(rd_addr) + ADDR_W'(4)));

   assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_ack && !rd_err) |=> (!rd_req || $stable(rd_addr)));

   assert_fail_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && rd_err) |=> (done && err && !rd_req));

   assert_wait_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> (TIMEOUT_CYC == 0 || wait_cnt < TIMEOUT_CYC));

   assert_phase_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && busy));

   assert_valid_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mac_valid |-> (done && !mac_addr[40]));

   assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && mac_addr == 48'd0));
endmodule

bind kw_cfg_loader kwl_checker #(.ADDR_W(ADDR_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_kwl_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .rd_req(rd_req), .rd_addr(rd_addr),
   .rd_ack(rd_ack), .rd_err(rd_err), .busy(busy), .done(done), .err(err),
   .mac_addr(mac_addr), .mac_valid(mac_valid)
);

// File: tb/kw_cfg_loader_tb_top.sv
`timescale 1ns/1ps
module kw_cfg_loader_tb_top;
   localparam int          AW   = 20;
   localparam int          TO   = 8;
   localparam logic [15:0] STA  = 16'h0140;
   localparam int          EEB  = 'h100;
   localparam int          FLB  = 'h1F000;

   logic clk = 0, rst_n = 0, start = 0, src_sel = 0;
   logic rd_ack = 0, rd_err = 0;
   logic [31:0] rd_data = 0;
   logic rd_req, busy, done, err, mac_valid;
   logic [AW-1:0] rd_addr;
   logic [47:0] mac_addr;

   int tests = 0, fails = 0;
   logic [31:0] img [0:15];
   int lat = 0, err_idx = -1, nacks = 0, wcnt = 0;
   bit addr_bad = 0;

   always #2 clk = ~clk;

   kw_cfg_loader #(.ADDR_W(AW), .TIMEOUT_CYC(TO), .STA_REG(STA)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .src_sel(src_sel),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_err(rd_err),
      .rd_data(rd_data), .busy(busy), .done(done), .err(err),
      .mac_addr(mac_addr), .mac_valid(mac_valid)
   );

   // responder: drives on negedge, DUT consumes at the following posedge
   always @(negedge clk) begin
      rd_ack = 0; rd_err = 0;
      if (rd_req) begin
         if (wcnt >= lat) begin
            wcnt = 0;
            if (rd_addr != AW'((src_sel ? FLB : EEB) + 4 * nacks)) addr_bad = 1;
            if (nacks == err_idx) rd_err = 1;
            else begin
               rd_ack  = 1;
               rd_data = (nacks < 16) ? img[nacks] : 32'h0;
               nacks++;
            end
         end else wcnt++;
      end else wcnt = 0;
   end

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] kw(logic [15:0] r);
      return {r, 8'hC3, 8'h5A};
   endfunction

   task automatic clear_img();
      for (int i = 0; i < 16; i++) img[i] = 32'h0;
   endtask

   // arithmetic model of the scan
   task automatic model(output logic [31:0] lo, output logic [15:0] hi,
                        output int nrd, output bit e);
      bit want = 0; logic [15:0] key = 0;
      lo = 0; hi = 0; nrd = 0; e = 0;
      if (lat >= TO) begin e = 1; return; end
      for (int i = 0; i < 17; i++) begin
         logic [31:0] d;
         if (i == err_idx) begin e = 1; return; end
         d = (i < 16) ? img[i] : 32'h0;
         nrd++;
         if (want) begin
            if (key == STA) lo = d;
            else if (key == STA + 16'd4) hi = d[15:0];
            want = 0;
         end else if (d[7:0] == 8'h5A) begin
            key = d[31:16]; want = 1;
         end else return;
      end
   endtask

   task automatic run(string tag, bit src, bit mid_start);
      logic [31:0] lo; logic [15:0] hi; int nrd; bit e;
      logic [47:0] m; int lim;
      model(lo, hi, nrd, e);
      m = {hi, lo};
      @(negedge clk);
      src_sel = src; nacks = 0; addr_bad = 0; start = 1;
      @(negedge clk); start = 0;
      if (mid_start) begin
         repeat (3) @(negedge clk);
         start = 1; @(negedge clk); start = 0;
      end
      lim = 0;
      while (!done && lim < 2000) begin @(negedge clk); lim++; end
      @(negedge clk);
      chk({tag, " R5 done"}, done, 1);
      chk({tag, " R5 req low"}, rd_req, 0);
      chk({tag, " R6/R7 err"}, err, e);
      chk({tag, " R1 reads"}, nacks, nrd);
      chk({tag, " R1/R2 addr seq"}, addr_bad, 0);
      chk({tag, " R8/R9 mac"}, mac_addr, m);
      chk({tag, " R10 valid"}, mac_valid, (m != 0) && !m[40]);
   endtask

   initial begin : watchdog
      #(4 * 150000);
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      clear_img();
      repeat (3) @(negedge clk);
      // R12 reset state
      chk("R12 rd_req", rd_req, 0); chk("R12 busy", busy, 0);
      chk("R12 done", done, 0);     chk("R12 err", err, 0);
      chk("R12 mac", mac_addr, 0);  chk("R12 valid", mac_valid, 0);
      rst_n = 1;
      @(negedge clk);
      chk("R12 idle after reset", done | busy | rd_req, 0);

      // R3 R8 R9 basic eeprom image
      img[0] = kw(STA); img[1] = 32'h6AF600DC;
      img[2] = kw(STA + 16'd4); img[3] = 32'h0000000B;
      run("basic_ee R3", 0, 0);
      chk("R9 byte0", mac_addr[47:40], 8'h00);
      chk("R9 byte5", mac_addr[7:0], 8'hDC);
      // R1 flash region
      run("basic_fl R1", 1, 0);

      // R4 data word carrying 0x5A is not a keyword; other register ignored (R8)
      clear_img();
      img[0] = kw(16'h0200); img[1] = 32'h1234565A;
      img[2] = kw(STA); img[3] = 32'h0000005A;
      img[4] = kw(STA + 16'd4); img[5] = 32'hFFFF0200;
      run("R4 R8 data_5A", 0, 0);
      chk("R8 high upper ignored", mac_addr[47:32], 16'h0200);

      // R10 multicast rejected and zero rejected
      clear_img();
      img[0] = kw(STA + 16'd4); img[1] = 32'h00000100; img[2] = kw(STA); img[3] = 1;
      run("R10 mcast", 0, 0);
      chk("R10 mcast invalid", mac_valid, 0);
      clear_img();
      img[0] = kw(STA); img[1] = 0;
      run("R10 zero", 1, 0);

      // R6 read failure mid scan keeps earlier values
      clear_img();
      img[0] = kw(STA); img[1] = 32'hA1B2C3D4; img[2] = kw(STA + 16'd4); img[3] = 32'h0202;
      err_idx = 2;
      run("R6 rd_err", 0, 0);
      chk("R6 kept low", mac_addr[31:0], 32'hA1B2C3D4);
      err_idx = -1;

      // R7 timeout boundary
      lat = TO - 1; run("R7 slow ok", 0, 0);
      lat = TO;     run("R7 timeout", 1, 0);
      chk("R7 timeout err", err, 1);
      lat = 0;

      // R11 start during scan ignored, then new scan clears words
      lat = 2;
      run("R11 mid start", 0, 1);
      lat = 0;
      chk("R11 kept result", mac_addr, 48'h02_02_A1B2C3D4);
      clear_img();
      run("R11 cleared", 0, 0);
      chk("R11 clear mac", mac_addr, 0);

      // sweep: region x latency x order x value
      for (int s = 0; s < 2; s++)
         for (int l = 0; l < 4; l++)
            for (int o = 0; o < 2; o++)
               for (int v = 0; v < 4; v++) begin
                  logic [15:0] hv; logic [31:0] lv;
                  hv = 16'(v * 16'h0181);
                  lv = 32'(32'h01020304 * (v + l + 1));
                  clear_img(); lat = l;
                  if (o == 0) begin
                     img[0] = kw(STA); img[1] = lv;
                     img[2] = kw(STA + 16'd4); img[3] = {16'h5A5A, hv};
                  end else begin
                     img[0] = kw(16'h0300); img[1] = 32'h5A5A005A;
                     img[2] = kw(STA + 16'd4); img[3] = {16'hABCD, hv};
                     img[4] = kw(STA); img[5] = lv; img[6] = 32'h000000A5;
                  end
                  run("sweep R3 R4 R9", s[0], 0);
               end
      lat = 0;

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule